// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Addressable Wake-up

This block receives asynchronous NRZ characters on a single serial line. It is clocked by the system clock and advanced by a one-cycle strobe that pulses sixteen times per bit period. Each received character is placed in a data register. Five sticky status flags report: a character is waiting, the line has gone idle, a character was lost, a bit was noisy, and the stop bit was bad.

Software reads the flags with a status-read strobe and the character with a data-read strobe. A data read that follows a status read clears the flags that status read saw.

On a multi-drop line a node can put itself to sleep with a wake-up control bit. While the bit is set, no flag can become set. The node wakes on one of two conditions, picked by a select input:
- a full character time of idle line, or
- a character whose most significant data bit is one (an address mark).

Detecting the chosen condition clears the control bit in hardware.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, every status flag, the wake-up control bit, the data register and the ninth-bit output are all 0.
- R2: In 8-bit mode (`nine_bit`=0) a frame is one low start bit, eight data bits sent least significant first, and one stop bit. When the stop bit is sampled, the byte appears on `rx_data` and `full_flag` becomes 1.
- R3: In 9-bit mode (`nine_bit`=1) nine data bits are received. The first eight go to `rx_data`. The ninth goes to `rx_bit8`.
- R4: Each bit is sampled at three consecutive ticks around its centre (phases 7, 8 and 9 of 0..15) and takes the majority value. `noise_flag` is set with the character when the three samples of any bit in it disagree.
- R5: `frame_flag` is set with the character when the stop bit votes 0.
- R6: If a character completes while `full_flag` is 1, `ovr_flag` becomes 1. The new character is dropped, and `rx_data` keeps the earlier one.
- R7: A `data_rd` strobe clears exactly the flags that were 1 at the most recent `stat_rd` strobe. A `data_rd` with no `stat_rd` since the previous clear leaves all flags unchanged. Only `data_rd` clears flags.
- R8: `idle_flag` becomes 1 after the line has stayed high for one whole character time since its last low. That time is 160 ticks in 8-bit mode and 176 in 9-bit mode.
- R9: While `wake_active` is 1, none of the five status flags can become set by received characters or by idle line.
- R10: With `wake_sel`=0, an idle character time clears `wake_active`. That idle period does not set `idle_flag`. Later characters are delivered normally.
- R11: With `wake_sel`=1, a character whose most significant data bit is 1 clears `wake_active`. That bit is bit 7 in 8-bit mode and the ninth bit in 9-bit mode. This waking character is itself delivered.
- R12: A falling edge whose mid-bit samples vote high is treated as a false start. The receiver goes back to waiting for a falling edge, and nothing is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe, 16 per bit period |
| rx_in | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1 selects nine data bits |
| wake_sel | input | 1 | Wake condition: 0 idle line, 1 address mark |
| wake_set | input | 1 | Pulse that sets the wake-up control bit |
| stat_rd | input | 1 | Status-read strobe |
| data_rd | input | 1 | Data-read strobe |
| rx_data | output | 8 | Received character, low eight bits |
| rx_bit8 | output | 1 | Ninth received bit (9-bit mode) |
| full_flag | output | 1 | Character waiting |
| idle_flag | output | 1 | Idle line detected |
| ovr_flag | output | 1 | Character lost to overrun |
| noise_flag | output | 1 | Non-unanimous samples in the character |
| frame_flag | output | 1 | Stop bit sampled low |
| wake_active | output | 1 | Wake-up control bit |

## Verification
A wrong bit counter or a misplaced sample phase shows within one frame: the byte on `rx_data` comes out shifted, or `frame_flag` rises on a clean frame. A lost clear snapshot shows at the first `data_rd` after a `stat_rd`: flags either stay set or clear too early. A stuck wake bit or a wrong idle counter shows within one character time. In that case characters are suppressed or leak through, and `wake_active` stays at 1 after a long idle line or after an address mark.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    // status flag positions inside the flag vector
    localparam int F_FULL  = 0;
    localparam int F_IDLE  = 1;
    localparam int F_OVR   = 2;
    localparam int F_NOISE = 3;
    localparam int F_FRAME = 4;
    localparam int N_FLAGS = 5;

    // widest frame: start + 9 data + stop
    localparam int MAX_FRAME_BITS = 11;
endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uwr_frame.sv
module uwr_frame #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic       nine,
    output logic       done_o,
    output logic [8:0] word_o,
    output logic       bad_stop_o,
    output logic       noisy_o
);
    import uwr_pkg::*;

    localparam int PH_W = $clog2(OSR);
    localparam logic [PH_W-1:0] PH_A   = PH_W'(OSR / 2 - 1);
    localparam logic [PH_W-1:0] PH_B   = PH_W'(OSR / 2);
    localparam logic [PH_W-1:0] PH_C   = PH_W'(OSR / 2 + 1);
    localparam logic [PH_W-1:0] PH_END = PH_W'(OSR - 1);

    typedef struct packed {
        rx_state_e       st;
        logic [PH_W-1:0] ph;
        logic [3:0]      nbit;
        logic [1:0]      smp;
        logic [8:0]      sh;
        logic            noisy;
        logic            done;
        logic            bad;
    } fr_t;

    fr_t fr_d, fr_q;
    logic maj, split;
    logic [3:0] last_bit;

    always_comb begin
        maj      = (fr_q.smp[0] & fr_q.smp[1]) | (fr_q.smp[0] & line) | (fr_q.smp[1] & line);
        split    = !((fr_q.smp[0] == fr_q.smp[1]) && (fr_q.smp[1] == line));
        last_bit = nine ? 4'd8 : 4'd7;

        fr_d      = fr_q;
        fr_d.done = 1'b0;

        if (tick) begin
            if (fr_q.st == ST_HUNT) begin
                if (!line) begin
                    fr_d.st    = ST_START;
                    fr_d.ph    = PH_W'(1);
                    fr_d.noisy = 1'b0;
                end
            end else begin
                fr_d.ph = (fr_q.ph == PH_END) ? '0 : fr_q.ph + PH_W'(1);
                if (fr_q.ph == PH_A) fr_d.smp[0] = line;
                if (fr_q.ph == PH_B) fr_d.smp[1] = line;

                case (fr_q.st)
                    ST_START: begin
                        if (fr_q.ph == PH_C) begin
                            if (maj) fr_d.st = ST_HUNT;
                            else     fr_d.noisy = fr_q.noisy | split;
                        end
                        if (fr_q.ph == PH_END) begin
                            fr_d.st   = ST_DATA;
                            fr_d.nbit = '0;
                        end
                    end
                    ST_DATA: begin
                        if (fr_q.ph == PH_C) begin
                            fr_d.sh    = {maj, fr_q.sh[8:1]};
                            fr_d.noisy = fr_q.noisy | split;
                        end
                        if (fr_q.ph == PH_END) begin
                            if (fr_q.nbit == last_bit) fr_d.st = ST_STOP;
                            else                       fr_d.nbit = fr_q.nbit + 4'd1;
                        end
                    end
                    ST_STOP: begin
                        if (fr_q.ph == PH_C) begin
                            fr_d.done  = 1'b1;
                            fr_d.bad   = !maj;
                            fr_d.noisy = fr_q.noisy | split;
                            fr_d.st    = ST_HUNT;
                        end
                    end
                    default: fr_d.st = ST_HUNT;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign done_o     = fr_q.done;
    assign word_o     = fr_q.sh;
    assign bad_stop_o = fr_q.bad;
    assign noisy_o    = fr_q.noisy;
endmodule

// File: rtl/uwr_idle.sv
module uwr_idle #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic nine,
    output logic idle_evt_o
);
    localparam int CNT_W = $clog2(uwr_pkg::MAX_FRAME_BITS * OSR + 1);
    localparam logic [CNT_W-1:0] LIM8 = CNT_W'((uwr_pkg::MAX_FRAME_BITS - 1) * OSR - 1);
    localparam logic [CNT_W-1:0] LIM9 = CNT_W'(uwr_pkg::MAX_FRAME_BITS * OSR - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             evt;
    } id_t;

    id_t id_d, id_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim      = nine ? LIM9 : LIM8;
        id_d     = id_q;
        id_d.evt = 1'b0;
        if (tick) begin
            if (!line) begin
                id_d.cnt   = '0;
                id_d.armed = 1'b1;
            end else if (id_q.cnt < lim) begin
                id_d.cnt = id_q.cnt + CNT_W'(1);
            end else if (id_q.armed) begin
                id_d.evt   = 1'b1;
                id_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) id_q <= '0;
        else        id_q <= id_d;
    end

    assign idle_evt_o = id_q.evt;
endmodule

// File: rtl/uwr_status.sv
module uwr_status (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         done,
    input  logic [8:0]                   word,
    input  logic                         bad_stop,
    input  logic                         noisy,
    input  logic                         idle_evt,
    input  logic                         nine,
    input  logic                         wake_sel,
    input  logic                         wake_set,
    input  logic                         stat_rd,
    input  logic                         data_rd,
    output logic [uwr_pkg::N_FLAGS-1:0]  flags_o,
    output logic [7:0]                   data_o,
    output logic                         bit8_o,
    output logic                         wake_o
);
    import uwr_pkg::*;

    typedef struct packed {
        logic [N_FLAGS-1:0] fl;
        logic [N_FLAGS-1:0] snap;
        logic               snap_v;
        logic [7:0]         dat;
        logic               b8;
        logic               wake;
    } sr_t;

    sr_t sr_d, sr_q;
    logic [N_FLAGS-1:0] set_v;
    logic eff_wake;

    always_comb begin
        sr_d     = sr_q;
        set_v    = '0;
        eff_wake = sr_q.wake;

        // address mark: most significant data bit is word[8] in both modes
        if (done && sr_q.wake && wake_sel && word[8]) begin
            sr_d.wake = 1'b0;
            eff_wake  = 1'b0;
        end

        if (done && !eff_wake) begin
            if (sr_q.fl[F_FULL]) begin
                set_v[F_OVR] = 1'b1;
            end else begin
                set_v[F_FULL]  = 1'b1;
                set_v[F_NOISE] = noisy;
                set_v[F_FRAME] = bad_stop;
                sr_d.dat       = nine ? word[7:0] : word[8:1];
                sr_d.b8        = nine & word[8];
            end
        end

        if (idle_evt) begin
            if (sr_q.wake) begin
                if (!wake_sel) sr_d.wake = 1'b0;
            end else begin
                set_v[F_IDLE] = 1'b1;
            end
        end

        if (data_rd && sr_q.snap_v) begin
            sr_d.fl     = sr_q.fl & ~sr_q.snap;
            sr_d.snap_v = 1'b0;
        end
        if (stat_rd) begin
            sr_d.snap   = sr_q.fl;
            sr_d.snap_v = 1'b1;
        end

        sr_d.fl = sr_d.fl | set_v;
        if (wake_set) sr_d.wake = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign flags_o = sr_q.fl;
    assign data_o  = sr_q.dat;
    assign bit8_o  = sr_q.b8;
    assign wake_o  = sr_q.wake;
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic       nine_bit,
    input  logic       wake_sel,
    input  logic       wake_set,
    input  logic       stat_rd,
    input  logic       data_rd,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       full_flag,
    output logic       idle_flag,
    output logic       ovr_flag,
    output logic       noise_flag,
    output logic       frame_flag,
    output logic       wake_active
);
    import uwr_pkg::*;

    logic line_s;
    logic fr_done, fr_bad, fr_noisy, idle_evt;
    logic [8:0] fr_word;
    logic [N_FLAGS-1:0] flags;

    uwr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(line_s)
    );

    uwr_frame #(.OSR(OSR)) frame_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s), .nine(nine_bit),
        .done_o(fr_done), .word_o(fr_word), .bad_stop_o(fr_bad), .noisy_o(fr_noisy)
    );

    uwr_idle #(.OSR(OSR)) idle_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s), .nine(nine_bit),
        .idle_evt_o(idle_evt)
    );

    uwr_status status_i (
        .clk(clk), .rst_n(rst_n), .done(fr_done), .word(fr_word), .bad_stop(fr_bad),
        .noisy(fr_noisy), .idle_evt(idle_evt), .nine(nine_bit), .wake_sel(wake_sel),
        .wake_set(wake_set), .stat_rd(stat_rd), .data_rd(data_rd),
        .flags_o(flags), .data_o(rx_data), .bit8_o(rx_bit8), .wake_o(wake_active)
    );

    assign full_flag  = flags[F_FULL];
    assign idle_flag  = flags[F_IDLE];
    assign ovr_flag   = flags[F_OVR];
    assign noise_flag = flags[F_NOISE];
    assign frame_flag = flags[F_FRAME];
endmodule

// File: rtl/uwr_chk.sv
module uwr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       data_rd,
    input logic [7:0] rx_data,
    input logic       full_flag,
    input logic       idle_flag,
    input logic       ovr_flag,
    input logic       noise_flag,
    input logic       frame_flag,
    input logic       wake_active
);
    // R9: asleep across the edge means no flag rises
    a_r9_quiet_when_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wake_active) && wake_active) |->
        !($rose(full_flag) || $rose(idle_flag) || $rose(ovr_flag) ||
          $rose(noise_flag) || $rose(frame_flag)));

    // R6: overrun only ever follows a held character
    a_r6_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(full_flag));

    // R6: a held character is never overwritten
    a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(full_flag) |-> $stable(rx_data));

    // R7: flags fall only after a data read
    a_r7_clear_on_data_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(full_flag) || $fell(idle_flag) || $fell(ovr_flag) ||
         $fell(noise_flag) || $fell(frame_flag)) |-> $past(data_rd));

    // R4 / R5: error flags arrive together with a loaded character
    a_r5_error_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_flag) || $rose(noise_flag)) |-> $rose(full_flag));
endmodule

bind uart_wake_rx uwr_chk chk_i (
    .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .rx_data(rx_data),
    .full_flag(full_flag), .idle_flag(idle_flag), .ovr_flag(ovr_flag),
    .noise_flag(noise_flag), .frame_flag(frame_flag), .wake_active(wake_active)
);

// File: tb/uart_wake_rx_tb_top.sv
`timescale 1ns/1ps
module uart_wake_rx_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic rx_in = 1'b1;
    logic nine_bit = 1'b0, wake_sel = 1'b0, wake_set = 1'b0;
    logic stat_rd = 1'b0, data_rd = 1'b0;
    logic [7:0] rx_data;
    logic rx_bit8, full_flag, idle_flag, ovr_flag, noise_flag, frame_flag, wake_active;
    logic [1:0] tcnt = '0;
    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tcnt   <= tcnt + 2'd1;
        tick16 <= (tcnt == 2'd3);
    end

    uart_wake_rx dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in), .nine_bit(nine_bit),
        .wake_sel(wake_sel), .wake_set(wake_set), .stat_rd(stat_rd), .data_rd(data_rd),
        .rx_data(rx_data), .rx_bit8(rx_bit8), .full_flag(full_flag), .idle_flag(idle_flag),
        .ovr_flag(ovr_flag), .noise_flag(noise_flag), .frame_flag(frame_flag),
        .wake_active(wake_active)
    );

    function automatic logic [7:0] exp_byte(input logic [8:0] w);
        return w[7:0];
    endfunction

    function automatic logic exp_mark(input logic [8:0] w, input bit nine_m);
        return nine_m ? w[8] : w[7];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one tick period of line value
    task automatic per(input logic v);
        rx_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pad(input int n);
        for (int i = 0; i < n; i++) per(1'b1);
    endtask

    // noisy_bit: data bit index whose centre sample is flipped, -1 for none
    task automatic send_frame(input logic [8:0] w, input bit nine_m, input bit stop_ok,
                              input int noisy_bit);
        int nb;
        nb = nine_m ? 9 : 8;
        for (int b = 0; b < nb + 2; b++) begin
            logic v;
            if (b == 0)           v = 1'b0;
            else if (b == nb + 1) v = stop_ok;
            else                  v = w[b-1];
            for (int p = 0; p < 16; p++)
                per((b >= 1 && b - 1 == noisy_bit && p == 8) ? ~v : v);
        end
        pad(stop_ok ? 4 : 24);
    endtask

    task automatic rd_stat();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic rd_data();
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
    endtask

    task automatic clear_all();
        rd_stat();
        rd_data();
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake_set = 1'b1;
        @(negedge clk) wake_set = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 full", full_flag, 0);
        chk("R1 idle", idle_flag, 0);
        chk("R1 ovr", ovr_flag, 0);
        chk("R1 noise", noise_flag, 0);
        chk("R1 frame", frame_flag, 0);
        chk("R1 wake", wake_active, 0);
        chk("R1 data", rx_data, 0);
        chk("R1 bit8", rx_bit8, 0);
        pad(20);

        // R2 basic 8-bit frame
        send_frame(9'h05A, 0, 1, -1);
        chk("R2 full", full_flag, 1);
        chk("R2 data", rx_data, exp_byte(9'h05A));
        chk("R2 noise clean", noise_flag, 0);
        chk("R2 frame clean", frame_flag, 0);

        // R7 data read alone leaves flags, status then data clears
        rd_data();
        chk("R7 data-only keeps full", full_flag, 1);
        clear_all();
        chk("R7 sequence clears full", full_flag, 0);

        // R4 noisy centre sample
        send_frame(9'h03C, 0, 1, 2);
        chk("R4 majority data", rx_data, 8'h3C);
        chk("R4 noise set", noise_flag, 1);
        clear_all();
        chk("R7 noise cleared", noise_flag, 0);

        // R5 bad stop bit
        send_frame(9'h081, 0, 0, -1);
        chk("R5 frame set", frame_flag, 1);
        chk("R5 full set", full_flag, 1);
        chk("R5 data", rx_data, 8'h81);
        clear_all();
        chk("R7 frame cleared", frame_flag, 0);

        // R6 overrun
        send_frame(9'h011, 0, 1, -1);
        send_frame(9'h022, 0, 1, -1);
        chk("R6 ovr set", ovr_flag, 1);
        chk("R6 old data kept", rx_data, 8'h11);
        clear_all();
        chk("R7 ovr cleared", ovr_flag, 0);
        chk("R7 full cleared", full_flag, 0);

        // R3 nine-bit mode
        nine_bit = 1'b1;
        send_frame(9'h13C, 1, 1, -1);
        chk("R3 data", rx_data, 8'h3C);
        chk("R3 bit8 one", rx_bit8, 1);
        clear_all();
        send_frame(9'h0C3, 1, 1, -1);
        chk("R3 data2", rx_data, 8'hC3);
        chk("R3 bit8 zero", rx_bit8, 0);
        clear_all();
        nine_bit = 1'b0;
        pad(8);

        // R8 idle line
        send_frame(9'h000, 0, 1, -1);
        clear_all();
        chk("R8 idle not yet", idle_flag, 0);
        pad(170);
        chk("R8 idle set", idle_flag, 1);
        clear_all();
        chk("R7 idle cleared", idle_flag, 0);

        // R12 false start
        for (int i = 0; i < 4; i++) per(1'b0);
        pad(200);
        chk("R12 no char", full_flag, 0);
        chk("R12 no frame err", frame_flag, 0);
        clear_all();

        // R9 / R11 address-mark wake
        wake_sel = 1'b1;
        pulse_wake();
        chk("R9 wake set", wake_active, 1);
        send_frame(9'h042, 0, 1, -1);
        chk("R9 suppressed full", full_flag, 0);
        chk("R9 still asleep", wake_active, 1);
        send_frame(9'h010, 0, 0, -1);
        chk("R9 suppressed frame", frame_flag, 0);
        pad(8);
        send_frame(9'h0A5, 0, 1, -1);
        chk("R11 mark expected", exp_mark(9'h0A5, 0), 1);
        chk("R11 woke", wake_active, 0);
        chk("R11 delivered", full_flag, 1);
        chk("R11 data", rx_data, 8'hA5);
        clear_all();

        // R10 idle wake
        wake_sel = 1'b0;
        pad(180);
        clear_all();
        pulse_wake();
        send_frame(9'h042, 0, 1, -1);
        chk("R9 idle-mode suppressed", full_flag, 0);
        chk("R10 asleep before idle", wake_active, 1);
        pad(170);
        chk("R10 woke on idle", wake_active, 0);
        chk("R10 idle flag quiet", idle_flag, 0);
        send_frame(9'h033, 0, 1, -1);
        chk("R10 delivered after wake", full_flag, 1);
        chk("R10 data", rx_data, 8'h33);
        clear_all();

        // random frames, R2 and R4
        for (int k = 0; k < 24; k++) begin
            logic [7:0] b;
            int nz;
            b  = 8'($urandom);
            nz = ($urandom % 3 == 0) ? int'($urandom % 8) : -1;
            send_frame({1'b0, b}, 0, 1, nz);
            chk("R2 rand full", full_flag, 1);
            chk("R2 rand data", rx_data, exp_byte({1'b0, b}));
            chk("R4 rand noise", noise_flag, (nz >= 0) ? 1 : 0);
            clear_all();
        end

        finish_run();
    end
endmodule